// File: doc/BRIEF.md
# Ethernet Receive Frame Validator

This block sits on a byte-wide receive path, between the line-side byte stream and a packet buffer. It finds the start of each frame by looking for a run of preamble bytes followed by the start delimiter. It then runs a CRC-32 over every byte after the delimiter, counts the bytes, and forwards them with a valid strobe and a last marker. Once the frame ends it gives a single status word: good or bad, whether the check sequence matched, and the frame length. On the same cycle it raises one-cycle pulses that external statistics counters can use to count each class of error.

Three configuration inputs change the result, and each must be held stable for the whole of a frame. Check-sequence stripping withholds the trailing four bytes and shortens the reported length by four. Ignore-CRC mode lets a frame with a check-sequence mismatch through as good, but it still raises the error pulse and clears the per-frame check-sequence status bit. Length-field checking discards a frame whose measured payload is shorter than the value in its length/type field. The length-field check applies only to frames inside the legal size window and only when the field holds a length, not a type.

Top module: `eth_rx_validator`

## Requirements
- R1: The frame body starts after zero or more 0x55 bytes followed by a 0xD5 byte. If any other byte value comes before the 0xD5, the block forwards nothing from that frame and gives no status for it.
- R2: A frame whose CRC-32 matches is reported with `eof_fcs_ok`=1 and `eof_good`=1, provided no other error applies. The CRC uses the reflected 0x04C11DB7 polynomial, starts at all ones, and the check sequence is sent least significant byte first. A correct frame leaves the reflected register at 0xDEBB20E3.
- R3: A frame within the size window whose CRC does not match gives `eof_good`=0, `eof_fcs_ok`=0 and a pulse on `cnt_fcs`.
- R4: With `cfg_ignore_crc`=1, a CRC-mismatched frame gives `eof_good`=1 when no other error applies. `cnt_fcs` still pulses and `eof_fcs_ok` is 0.
- R5: With `cfg_strip_fcs`=0, all bytes including the 4-byte check sequence are forwarded and `eof_len` is the total byte count. With `cfg_strip_fcs`=1, the last 4 bytes are withheld and `eof_len` is the total minus 4.
- R6: A frame shorter than MIN_LEN bytes (default 64, check sequence included) is bad and pulses `cnt_runt`. It raises no CRC or alignment pulse.
- R7: A frame longer than MAX_LEN bytes (default 1518) is bad and pulses `cnt_long`. Forwarding stops after the first MAX_LEN bytes, and that frame never raises `fwd_last`.
- R8: A frame longer than JABBER_LEN bytes (default 2048) pulses `cnt_jabber` instead of `cnt_long`. At most one of the runt, long and jabber pulses is raised.
- R9: When `rx_dribble`=1 on the final byte and the CRC fails, `cnt_align` pulses instead of `cnt_fcs`. A dribble with a matching CRC does not make the frame bad.
- R10: If `rx_sym_err` is raised on any body byte, the frame is bad and `cnt_symbol` pulses.
- R11: With `cfg_len_check`=1, a frame of MIN_LEN..MAX_LEN bytes is bad, with no error pulse, when the big-endian field in body bytes 13 and 14 is below 0x0600 and exceeds the measured payload (total minus 18). A field of 0x0600 or more, a field equal to the payload, or `cfg_len_check`=0 has no effect on the result.
- R12: The status and error pulses appear one cycle after the final body byte is accepted, on the same cycle as `fwd_last`. Error pulses never appear without `eof_valid`.
- R13: During and straight after reset, `fwd_valid`, `fwd_last`, `eof_valid` and all error pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_strip_fcs | input | 1 | Withhold check sequence and shorten reported length |
| cfg_ignore_crc | input | 1 | Accept CRC-mismatched frames as good |
| cfg_len_check | input | 1 | Enable the length-field discard rule |
| rx_valid | input | 1 | Byte present on `rx_data` |
| rx_data | input | 8 | Received byte, preamble included |
| rx_end | input | 1 | This byte is the last of the reception |
| rx_dribble | input | 1 | Reception ended off a byte boundary (valid with `rx_end`) |
| rx_sym_err | input | 1 | Line symbol error on this byte |
| fwd_valid | output | 1 | Forwarded byte present |
| fwd_data | output | 8 | Forwarded byte |
| fwd_last | output | 1 | Final forwarded byte of a complete frame |
| eof_valid | output | 1 | Frame status present |
| eof_good | output | 1 | Frame is to be kept |
| eof_fcs_ok | output | 1 | Check sequence matched |
| eof_len | output | 16 | Reported frame length in bytes |
| cnt_align | output | 1 | Alignment error pulse |
| cnt_fcs | output | 1 | Check-sequence error pulse |
| cnt_runt | output | 1 | Short-frame error pulse |
| cnt_long | output | 1 | Long-frame error pulse |
| cnt_jabber | output | 1 | Jabber error pulse |
| cnt_symbol | output | 1 | Receive symbol error pulse |

## Verification
Frames are built with a computed check sequence and then sent clean, with one check-sequence bit flipped, with a trailing dribble, and with a symbol error. Comparing these separates the CRC, alignment and symbol classifications, and shows that a dribble alone is harmless. Sizes just inside and outside each bound (40, 64, 1518, 1519 and 2100 bytes) show which size class wins and where forwarding is cut off. Length-field values equal to the payload, one above it, 0x05FF and 0x0600 separate the discard rule from the type exemption. Each of these runs with stripping on and off, so the withheld bytes and the shortened length are compared against the same frame.

// File: rtl/eth_rxv_pkg.sv
package eth_rxv_pkg;

    localparam int LEN_W     = 16;
    localparam int FCS_BYTES = 4;
    localparam int HDR_BYTES = 14;

    localparam logic [7:0]  PRE_BYTE         = 8'h55;
    localparam logic [7:0]  SFD_BYTE         = 8'hD5;
    localparam logic [31:0] CRC_SEED         = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_POLY_REFL    = 32'hEDB8_8320;
    localparam logic [31:0] CRC_GOOD_RESIDUE = 32'hDEBB_20E3;
    localparam logic [15:0] TYPE_THRESHOLD   = 16'h0600;
    localparam int          LFIELD_HI_IDX    = 12;
    localparam int          LFIELD_LO_IDX    = 13;

    typedef logic [LEN_W-1:0] len_t;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_BODY = 2'd1,
        ST_SKIP = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic align;
        logic fcs;
        logic runt;
        logic long_f;
        logic jabber;
        logic symbol;
    } err_pulse_t;

    typedef struct packed {
        logic good;
        logic fcs_ok;
        len_t len;
    } frame_status_t;

    function automatic logic [31:0] crc32_step(input logic [31:0] c_in, input logic [7:0] d);
        logic [31:0] c;
        c = c_in ^ {24'd0, d};
        for (int b = 0; b < 8; b++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/eth_rxv_crc.sv
module eth_rxv_crc
    import eth_rxv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       en,
    input  logic [7:0] data,
    output logic       match
);
    logic [31:0] crc_q;
    logic [31:0] crc_d;

    assign crc_d = crc32_step(crc_q, data);
    assign match = (crc_d == CRC_GOOD_RESIDUE);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            crc_q <= CRC_SEED;
        end else if (en) begin
            crc_q <= crc_d;
        end
    end
endmodule

// File: rtl/eth_rxv_len_ctr.sv
module eth_rxv_len_ctr
    import eth_rxv_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        en,
    input  logic [7:0]  data,
    output len_t        count_q,
    output len_t        count_d,
    output logic [15:0] field_q
);
    localparam len_t HI_IDX = len_t'(LFIELD_HI_IDX);
    localparam len_t LO_IDX = len_t'(LFIELD_LO_IDX);

    assign count_d = (count_q == '1) ? count_q : count_q + len_t'(1);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count_q <= '0;
            field_q <= '0;
        end else if (en) begin
            count_q <= count_d;
            if (count_q == HI_IDX) field_q[15:8] <= data;
            if (count_q == LO_IDX) field_q[7:0]  <= data;
        end
    end
endmodule

// File: rtl/eth_rxv_fwd.sv
module eth_rxv_fwd
    import eth_rxv_pkg::*;
#(
    parameter int DEPTH = FCS_BYTES
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       beat,
    input  logic [7:0] data,
    input  logic       last,
    input  logic       strip,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_last
);
    localparam int FW = $clog2(DEPTH + 1);
    localparam logic [FW-1:0] FULL = FW'(DEPTH);

    logic [DEPTH-1:0][7:0] dly_q;
    logic [FW-1:0]         fill_q;
    logic                  emit;
    logic [7:0]            emit_data;

    always_comb begin
        if (strip) begin
            emit      = beat && (fill_q == FULL);
            emit_data = dly_q[DEPTH-1];
        end else begin
            emit      = beat;
            emit_data = data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            fill_q <= '0;
        end else if (beat && fill_q != FULL) begin
            fill_q <= fill_q + FW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dly_q <= '0;
        end else if (beat) begin
            dly_q <= {dly_q[DEPTH-2:0], data};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else begin
            out_valid <= emit;
            out_last  <= emit && last;
            if (emit) out_data <= emit_data;
        end
    end

    AST_STRIP_HOLDS_BACK: assert property (@(posedge clk) disable iff (rst)
        (strip && beat && fill_q != FULL) |=> !out_valid); // R5
endmodule

// File: rtl/eth_rxv_classify.sv
module eth_rxv_classify
    import eth_rxv_pkg::*;
#(
    parameter int MIN_LEN    = 64,
    parameter int MAX_LEN    = 1518,
    parameter int JABBER_LEN = 2048
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fire,
    input  len_t          total,
    input  logic          crc_ok,
    input  logic          dribble,
    input  logic          sym,
    input  logic [15:0]   lfield,
    input  logic          cfg_strip,
    input  logic          cfg_ign,
    input  logic          cfg_lchk,
    output logic          st_valid,
    output frame_status_t st,
    output err_pulse_t    pulse
);
    localparam len_t MIN_L = len_t'(MIN_LEN);
    localparam len_t MAX_L = len_t'(MAX_LEN);
    localparam len_t JAB_L = len_t'(JABBER_LEN);
    localparam len_t OVH_L = len_t'(HDR_BYTES + FCS_BYTES);
    localparam len_t FCS_L = len_t'(FCS_BYTES);

    logic          is_runt, is_jab, is_long, in_range, len_err;
    len_t          payload;
    frame_status_t st_d;
    err_pulse_t    pulse_d;

    always_comb begin
        is_runt  = total < MIN_L;
        is_jab   = total > JAB_L;
        is_long  = (total > MAX_L) && !is_jab;
        in_range = !is_runt && (total <= MAX_L);
        payload  = total - OVH_L;
        len_err  = cfg_lchk && in_range && (lfield < TYPE_THRESHOLD)
                   && (payload < len_t'(lfield));

        pulse_d        = '0;
        pulse_d.align  = in_range && !crc_ok && dribble;
        pulse_d.fcs    = in_range && !crc_ok && !dribble;
        pulse_d.runt   = is_runt;
        pulse_d.long_f = is_long;
        pulse_d.jabber = is_jab;
        pulse_d.symbol = sym;

        st_d.good   = in_range && !sym && (crc_ok || cfg_ign) && !len_err;
        st_d.fcs_ok = crc_ok;
        if (cfg_strip) begin
            st_d.len = (total >= FCS_L) ? total - FCS_L : '0;
        end else begin
            st_d.len = total;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_valid <= 1'b0;
            st       <= '0;
            pulse    <= '0;
        end else begin
            st_valid <= fire;
            pulse    <= fire ? pulse_d : '0;
            if (fire) st <= st_d;
        end
    end

    AST_PULSE_WITH_EOF: assert property (@(posedge clk) disable iff (rst)
        (pulse != '0) |-> st_valid); // R12
    AST_SIZE_CLASS_ONE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pulse.runt, pulse.long_f, pulse.jabber})); // R8
    AST_RUNT_BAD: assert property (@(posedge clk) disable iff (rst)
        (st_valid && pulse.runt) |-> !st.good); // R6
    AST_CRC_STRICT: assert property (@(posedge clk) disable iff (rst)
        (st_valid && !st.fcs_ok && !$past(cfg_ign)) |-> !st.good); // R3
    AST_SYMBOL_BAD: assert property (@(posedge clk) disable iff (rst)
        (st_valid && pulse.symbol) |-> !st.good); // R10
endmodule

// File: rtl/eth_rx_validator.sv
module eth_rx_validator
    import eth_rxv_pkg::*;
#(
    parameter int MIN_LEN    = 64,
    parameter int MAX_LEN    = 1518,
    parameter int JABBER_LEN = 2048
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_strip_fcs,
    input  logic        cfg_ignore_crc,
    input  logic        cfg_len_check,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_end,
    input  logic        rx_dribble,
    input  logic        rx_sym_err,
    output logic        fwd_valid,
    output logic [7:0]  fwd_data,
    output logic        fwd_last,
    output logic        eof_valid,
    output logic        eof_good,
    output logic        eof_fcs_ok,
    output logic [15:0] eof_len,
    output logic        cnt_align,
    output logic        cnt_fcs,
    output logic        cnt_runt,
    output logic        cnt_long,
    output logic        cnt_jabber,
    output logic        cnt_symbol
);
    localparam len_t MAX_L = len_t'(MAX_LEN);

    rx_state_e     st_q, st_d;
    logic          body_beat, sof, eof_beat, fwd_beat;
    logic          sym_q, sym_any, crc_ok;
    len_t          count_q, count_d;
    logic [15:0]   field_q;
    frame_status_t status;
    err_pulse_t    pulses;

    assign body_beat = rx_valid && (st_q == ST_BODY);
    assign sof       = rx_valid && (st_q == ST_HUNT) && (rx_data == SFD_BYTE) && !rx_end;
    assign eof_beat  = body_beat && rx_end;
    assign fwd_beat  = body_beat && (count_q < MAX_L);
    assign sym_any   = sym_q || (body_beat && rx_sym_err);

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_HUNT: if (rx_valid && !rx_end) begin
                if (rx_data == SFD_BYTE)      st_d = ST_BODY;
                else if (rx_data != PRE_BYTE) st_d = ST_SKIP;
            end
            ST_BODY: if (rx_valid && rx_end) st_d = ST_HUNT;
            ST_SKIP: if (rx_valid && rx_end) st_d = ST_HUNT;
            default: st_d = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_HUNT;
        else     st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (rst || sof)                     sym_q <= 1'b0;
        else if (body_beat && rx_sym_err)   sym_q <= 1'b1;
    end

    eth_rxv_crc u_crc (
        .clk   (clk),
        .rst   (rst),
        .clear (sof),
        .en    (body_beat),
        .data  (rx_data),
        .match (crc_ok)
    );

    eth_rxv_len_ctr u_len (
        .clk     (clk),
        .rst     (rst),
        .clear   (sof),
        .en      (body_beat),
        .data    (rx_data),
        .count_q (count_q),
        .count_d (count_d),
        .field_q (field_q)
    );

    eth_rxv_fwd #(.DEPTH(FCS_BYTES)) u_fwd (
        .clk       (clk),
        .rst       (rst),
        .clear     (st_q != ST_BODY),
        .beat      (fwd_beat),
        .data      (rx_data),
        .last      (rx_end),
        .strip     (cfg_strip_fcs),
        .out_valid (fwd_valid),
        .out_data  (fwd_data),
        .out_last  (fwd_last)
    );

    eth_rxv_classify #(
        .MIN_LEN    (MIN_LEN),
        .MAX_LEN    (MAX_LEN),
        .JABBER_LEN (JABBER_LEN)
    ) u_cls (
        .clk       (clk),
        .rst       (rst),
        .fire      (eof_beat),
        .total     (count_d),
        .crc_ok    (crc_ok),
        .dribble   (rx_dribble),
        .sym       (sym_any),
        .lfield    (field_q),
        .cfg_strip (cfg_strip_fcs),
        .cfg_ign   (cfg_ignore_crc),
        .cfg_lchk  (cfg_len_check),
        .st_valid  (eof_valid),
        .st        (status),
        .pulse     (pulses)
    );

    assign eof_good   = status.good;
    assign eof_fcs_ok = status.fcs_ok;
    assign eof_len    = status.len;
    assign cnt_align  = pulses.align;
    assign cnt_fcs    = pulses.fcs;
    assign cnt_runt   = pulses.runt;
    assign cnt_long   = pulses.long_f;
    assign cnt_jabber = pulses.jabber;
    assign cnt_symbol = pulses.symbol;

    // Output-side byte tally per frame, used only by the checks below.
    len_t out_cnt_q;
    len_t out_cnt_now;
    assign out_cnt_now = out_cnt_q + len_t'(fwd_valid);

    always_ff @(posedge clk) begin
        if (rst || eof_valid) out_cnt_q <= '0;
        else if (fwd_valid)   out_cnt_q <= out_cnt_now;
    end

    AST_FWD_CAPPED: assert property (@(posedge clk) disable iff (rst)
        out_cnt_now <= MAX_L); // R7
    AST_LEN_MATCHES_OUT: assert property (@(posedge clk) disable iff (rst)
        (eof_valid && !cnt_long && !cnt_jabber) |-> (out_cnt_now == eof_len)); // R5
    AST_LAST_AT_EOF: assert property (@(posedge clk) disable iff (rst)
        fwd_last |-> eof_valid); // R12
    AST_TRUNC_NO_LAST: assert property (@(posedge clk) disable iff (rst)
        (eof_valid && (cnt_long || cnt_jabber)) |-> !fwd_last); // R7
endmodule

// File: tb/eth_rx_validator_test.sv
`timescale 1ns/1ps
module eth_rx_validator_test;

    typedef struct packed {
        logic [15:0] n;
        logic        strip;
        logic        ign;
        logic        lchk;
        logic        bad;
        logic        drib;
        logic        sym;
        logic [15:0] lfield;
        logic        good;
        logic        fok;
        logic [5:0]  pulses;
    } vec_t;

    localparam int NV     = 18;
    localparam int MAXL   = 1518;
    localparam int LIMIT  = 150000;

    // pulses order: align, fcs, runt, long, jabber, symbol
    localparam vec_t VECS [NV] = '{
        '{16'd64,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0800, 1'b1, 1'b1, 6'b000000},
        '{16'd100,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0800, 1'b1, 1'b1, 6'b000000},
        '{16'd80,   1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0800, 1'b0, 1'b0, 6'b010000},
        '{16'd80,   1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0800, 1'b1, 1'b0, 6'b010000},
        '{16'd80,   1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0800, 1'b0, 1'b0, 6'b100000},
        '{16'd80,   1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0800, 1'b1, 1'b1, 6'b000000},
        '{16'd40,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0800, 1'b0, 1'b1, 6'b001000},
        '{16'd1518, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0800, 1'b1, 1'b1, 6'b000000},
        '{16'd1519, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0800, 1'b0, 1'b1, 6'b000100},
        '{16'd2100, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0800, 1'b0, 1'b1, 6'b000010},
        '{16'd80,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0800, 1'b0, 1'b1, 6'b000001},
        '{16'd100,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'd82,   1'b1, 1'b1, 6'b000000},
        '{16'd100,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'd83,   1'b0, 1'b1, 6'b000000},
        '{16'd100,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0600, 1'b1, 1'b1, 6'b000000},
        '{16'd100,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h05FF, 1'b0, 1'b1, 6'b000000},
        '{16'd100,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h01F4, 1'b1, 1'b1, 6'b000000},
        '{16'd70,   1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0800, 1'b1, 1'b0, 6'b010000},
        '{16'd40,   1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0800, 1'b0, 1'b0, 6'b001000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_strip_fcs = 1'b0, cfg_ignore_crc = 1'b0, cfg_len_check = 1'b0;
    logic        rx_valid = 1'b0, rx_end = 1'b0, rx_dribble = 1'b0, rx_sym_err = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        fwd_valid, fwd_last, eof_valid, eof_good, eof_fcs_ok;
    logic [7:0]  fwd_data;
    logic [15:0] eof_len;
    logic        cnt_align, cnt_fcs, cnt_runt, cnt_long, cnt_jabber, cnt_symbol;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;
    bit done = 1'b0;

    logic [7:0] frm [0:2199];
    logic [7:0] got [0:2199];
    int         ngot = 0;
    bit         got_last = 1'b0;
    bit         seen_eof = 1'b0;
    logic       s_good, s_fok;
    logic [15:0] s_len;
    logic [5:0]  s_pulses;

    always #4 clk = ~clk;

    eth_rx_validator uut (
        .clk(clk), .rst(rst),
        .cfg_strip_fcs(cfg_strip_fcs), .cfg_ignore_crc(cfg_ignore_crc), .cfg_len_check(cfg_len_check),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_end(rx_end), .rx_dribble(rx_dribble),
        .rx_sym_err(rx_sym_err),
        .fwd_valid(fwd_valid), .fwd_data(fwd_data), .fwd_last(fwd_last),
        .eof_valid(eof_valid), .eof_good(eof_good), .eof_fcs_ok(eof_fcs_ok), .eof_len(eof_len),
        .cnt_align(cnt_align), .cnt_fcs(cnt_fcs), .cnt_runt(cnt_runt), .cnt_long(cnt_long),
        .cnt_jabber(cnt_jabber), .cnt_symbol(cnt_symbol)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (fwd_valid) begin
                if (ngot < 2200) got[ngot] = fwd_data;
                ngot = ngot + 1;
                if (fwd_last) got_last = 1'b1;
            end
            if (eof_valid) begin
                seen_eof = 1'b1;
                s_good   = eof_good;
                s_fok    = eof_fcs_ok;
                s_len    = eof_len;
                s_pulses = {cnt_align, cnt_fcs, cnt_runt, cnt_long, cnt_jabber, cnt_symbol};
            end
        end
    end

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > LIMIT && !done) begin
            nchk = nchk + 1;
            nerr = nerr + 1;
            $display("FAIL watchdog: actual %0d cycles expected under %0d", cyc, LIMIT);
            summary();
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk = nchk + 1;
        if (act != exp) begin
            nerr = nerr + 1;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input int len);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < len; i++) begin
            c = c ^ {24'd0, frm[i]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        end
        return c;
    endfunction

    task automatic build(input int n, input logic [15:0] lf, input bit corrupt);
        logic [31:0] fcs;
        for (int i = 0; i < n - 4; i++) frm[i] = 8'((i * 7 + 3) & 255);
        frm[12] = lf[15:8];
        frm[13] = lf[7:0];
        fcs = ~ref_crc(n - 4);
        for (int k = 0; k < 4; k++) frm[n - 4 + k] = fcs[8*k +: 8];
        if (corrupt) frm[n - 4] = frm[n - 4] ^ 8'h01;
    endtask

    task automatic put(input logic [7:0] d, input bit last, input bit drib, input bit sym);
        rx_valid   = 1'b1;
        rx_data    = d;
        rx_end     = last;
        rx_dribble = drib;
        rx_sym_err = sym;
        @(posedge clk); #1;
    endtask

    task automatic send(input int n, input bit drib, input bit sym, input bit badpre, input int npre);
        ngot = 0; got_last = 1'b0; seen_eof = 1'b0;
        for (int p = 0; p < npre; p++) put((badpre && p == 2) ? 8'h33 : 8'h55, 1'b0, 1'b0, 1'b0);
        put(8'hD5, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < n; i++) put(frm[i], i == n - 1, drib && i == n - 1, sym && i == 20);
        rx_valid = 1'b0; rx_end = 1'b0; rx_dribble = 1'b0; rx_sym_err = 1'b0;
        repeat (3) @(negedge clk);
        #1;
    endtask

    task automatic run_vec(input vec_t v);
        int n, exp_cnt, mism;
        n = int'(v.n);
        cfg_strip_fcs  = v.strip;
        cfg_ignore_crc = v.ign;
        cfg_len_check  = v.lchk;
        build(n, v.lfield, v.bad);
        send(n, v.drib, v.sym, 1'b0, 7);
        exp_cnt = (n > MAXL) ? MAXL : n;
        if (v.strip) exp_cnt = exp_cnt - 4;
        chk("R12", "status seen", int'(seen_eof), 1);
        chk(v.good ? "R2" : "R3", "good", int'(s_good), int'(v.good));
        chk(v.ign ? "R4" : "R2", "fcs_ok", int'(s_fok), int'(v.fok));
        chk(v.pulses[3] ? "R6" : (v.pulses[2] ? "R7" : (v.pulses[1] ? "R8" : "R9")),
            "pulses", int'(s_pulses), int'(v.pulses));
        chk("R5", "length", int'(s_len), v.strip ? n - 4 : n);
        chk((n > MAXL) ? "R7" : "R5", "byte count", ngot, exp_cnt);
        mism = 0;
        for (int i = 0; i < exp_cnt && i < ngot; i++) if (got[i] !== frm[i]) mism++;
        chk("R5", "byte mismatches", mism, 0);
        chk((n > MAXL) ? "R7" : "R12", "last marker", int'(got_last), (n > MAXL) ? 0 : 1);
    endtask

    initial begin
        @(posedge clk); #1;
        // R13: outputs held quiet during reset
        chk("R13", "fwd_valid in reset", int'(fwd_valid), 0);
        chk("R13", "eof_valid in reset", int'(eof_valid), 0);
        chk("R13", "pulses in reset",
            int'({cnt_align, cnt_fcs, cnt_runt, cnt_long, cnt_jabber, cnt_symbol}), 0);
        repeat (3) @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        chk("R13", "fwd_last after reset", int'(fwd_last), 0);
        chk("R13", "eof_valid after reset", int'(eof_valid), 0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R10 sanity: symbol vector gave a bad frame (covered in table), now R1 cases
        cfg_strip_fcs = 1'b0; cfg_ignore_crc = 1'b0; cfg_len_check = 1'b0;
        build(64, 16'h0800, 1'b0);
        send(64, 1'b0, 1'b0, 1'b1, 7);
        chk("R1", "bad preamble status", int'(seen_eof), 0);
        chk("R1", "bad preamble bytes", ngot, 0);

        send(64, 1'b0, 1'b0, 1'b0, 0);
        chk("R1", "bare delimiter status", int'(seen_eof), 1);
        chk("R1", "bare delimiter good", int'(s_good), 1);
        chk("R1", "bare delimiter bytes", ngot, 64);

        // R11: length-field mismatch ignored while check disabled, with stripping on
        cfg_strip_fcs = 1'b1;
        build(100, 16'd300, 1'b0);
        send(100, 1'b0, 1'b0, 1'b0, 3);
        chk("R11", "check off good", int'(s_good), 1);
        chk("R5", "strip bytes", ngot, 96);
        cfg_len_check = 1'b1;
        send(100, 1'b0, 1'b0, 1'b0, 3);
        chk("R11", "check on good", int'(s_good), 0);
        chk("R11", "check on pulses",
            int'(s_pulses), 0);

        summary();
    end

endmodule